// File: doc/BRIEF.md
# Reconfigurable Multiplier-Free Approximate DCT (16-point or dual 8-point)

This block is a one-dimensional transform datapath that turns sixteen signed samples into sixteen approximate DCT coefficients using only adders and subtractors. A single mode input selects the job done on each sample set. With mode high, the sixteen samples form one 16-point transform. With mode low, the lower eight and the upper eight samples are two independent 8-point transforms computed side by side.

Internally, a sum/difference butterfly folds the sixteen samples into two 8-element vectors. Two identical 8-point approximate cores run a fixed integer matrix whose entries are 0 and ±1. Selection multiplexers feed each core either its folded vector or its raw half of the input. An output network then interleaves or concatenates the two cores' results. A full set of samples enters every cycle. Each set carries its own mode bit and valid flag through the pipeline, so the mode may change from one cycle to the next.

Word growth is kept in full: there is no rounding, truncation, scaling or normalisation anywhere in the block.

Top module: `dct_reconfig16`

## Requirements
- R1: While reset is held, and after its release until the first accepted set has crossed the pipeline, `out_valid` is 0.
- R2: Samples are signed two's complement, lane i at bits [i*IN_W +: IN_W]. With `in_mode`=1 the block forms a(i)=x(i)+x(15-i) for i=0..7. Output lane 2k equals row k of the core matrix applied to a.
- R3: With `in_mode`=1, the block forms b(i)=x(i)-x(15-i). Output lane 2k+1 equals row k of the core matrix applied to b.
- R4: With `in_mode`=0, output lanes 0..7 equal the core matrix applied to x(0..7), in natural order.
- R5: With `in_mode`=0, output lanes 8..15 equal the core matrix applied to x(8..15). Lower input lanes have no effect on them.
- R6: The core matrix has these rows, with columns 0..7:
  - row 0: 1 1 1 1 1 1 1 1
  - row 1: 1 1 1 0 0 -1 -1 -1
  - row 2: 1 0 0 -1 -1 0 0 1
  - row 3: 1 0 -1 -1 1 1 0 -1
  - row 4: 1 -1 -1 1 1 -1 -1 1
  - row 5: 1 -1 0 1 -1 0 1 -1
  - row 6: 0 -1 1 0 0 1 -1 0
  - row 7: 0 -1 1 -1 1 -1 1 0
- R7: With pipelining on, a set accepted at a rising edge with `in_valid`=1 appears with `out_valid`=1 exactly 6 cycles later. This is 4 adder stages plus the input and output registers. `out_valid` is never raised without such a set.
- R8: Sets may arrive back to back at one per cycle. Each set is transformed in the mode sampled with it, even when the mode alternates every cycle.
- R9: Each coefficient is IN_W+4 bits wide, signed, at lane j bits [j*(IN_W+4) +: IN_W+4]. Full-scale inputs of either polarity never wrap in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Sample set present this cycle |
| in_mode | input | 1 | 1: one 16-point transform, 0: two 8-point transforms |
| in_samples | input | 16*IN_W | Sixteen signed samples, lane i at [i*IN_W +: IN_W] |
| out_valid | output | 1 | Coefficient set present |
| out_coefs | output | 16*(IN_W+4) | Sixteen signed coefficients, lane j at [j*(IN_W+4) +: IN_W+4] |

## Verification
Every result is due exactly six rising edges after its set was accepted. The driver stamps each expected set with the edge count when it pushes it into the scoreboard. The monitor samples on the falling edge, pops one entry per `out_valid`, and checks both the six-edge distance and the coefficient values, so an early, late, missing or extra result shows up as a latency or queue error. Back-to-back bursts with alternating modes, impulse columns, full-scale patterns and gaps in `in_valid` all travel through the same queue.

// File: rtl/dct_recfg_pkg.sv
`timescale 1ns/1ps
package dct_recfg_pkg;

    // Transform size selected per sample set.
    typedef enum logic {
        SIZE_PAIR8 = 1'b0,
        SIZE_ONE16 = 1'b1
    } size_mode_e;

    localparam int unsigned LANES = 16;
    localparam int unsigned HALF  = LANES / 2;

endpackage

// File: rtl/dct_stage_reg.sv
`timescale 1ns/1ps
module dct_stage_reg #(
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic         vld_o,
    output logic [W-1:0] d_o
);

    generate
        if (PIPE) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vld_o <= 1'b0;
                else        vld_o <= vld_i;
            end

            always_ff @(posedge clk) begin
                if (vld_i) d_o <= d_i;
            end
        end else begin : g_wire
            assign vld_o = vld_i;
            assign d_o   = d_i;
        end
    endgenerate

endmodule

// File: rtl/dct_prep.sv
`timescale 1ns/1ps
module dct_prep
    import dct_recfg_pkg::*;
#(
    parameter int IN_W = 8,
    parameter bit PIPE = 1'b1,
    localparam int CW  = IN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_i,
    input  size_mode_e         mode_i,
    input  logic [16*IN_W-1:0] smp_i,
    output logic               vld_o,
    output size_mode_e         mode_o,
    output logic [8*CW-1:0]    lo_o,
    output logic [8*CW-1:0]    hi_o
);

    logic signed [IN_W-1:0] xs [16];
    logic [8*CW-1:0] lo_c;
    logic [8*CW-1:0] hi_c;
    logic [8*CW-1:0] lo_q;
    logic [8*CW-1:0] hi_q;
    logic            mode_q;

    generate
        for (genvar i = 0; i < 16; i++) begin : g_unpack
            assign xs[i] = $signed(smp_i[i*IN_W +: IN_W]);
        end

        for (genvar i = 0; i < 8; i++) begin : g_lane
            logic signed [CW-1:0] fold_sum;
            logic signed [CW-1:0] fold_dif;

            assign fold_sum = CW'(xs[i]) + CW'(xs[15-i]);
            assign fold_dif = CW'(xs[i]) - CW'(xs[15-i]);

            always_comb begin
                unique case (mode_i)
                    SIZE_ONE16: begin
                        lo_c[i*CW +: CW] = fold_sum;
                        hi_c[i*CW +: CW] = fold_dif;
                    end
                    SIZE_PAIR8: begin
                        lo_c[i*CW +: CW] = CW'(xs[i]);
                        hi_c[i*CW +: CW] = CW'(xs[8+i]);
                    end
                    default: begin
                        lo_c[i*CW +: CW] = '0;
                        hi_c[i*CW +: CW] = '0;
                    end
                endcase
            end
        end
    endgenerate

    dct_stage_reg #(.W(1 + 16*CW), .PIPE(PIPE)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (vld_i),
        .d_i   ({mode_i, hi_c, lo_c}),
        .vld_o (vld_o),
        .d_o   ({mode_q, hi_q, lo_q})
    );

    assign mode_o = size_mode_e'(mode_q);
    assign lo_o   = lo_q;
    assign hi_o   = hi_q;

    generate
        if (PIPE) begin : g_chk
            for (genvar i = 0; i < 8; i++) begin : g_lane_chk
                // R2: folded pair recombines to twice the near sample
                p_fold_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    (vld_o && mode_o == SIZE_ONE16) |->
                    (int'($signed(lo_o[i*CW +: CW])) + int'($signed(hi_o[i*CW +: CW]))
                        == 2 * int'($past(xs[i]))));
                // R5: in pair mode the upper core sees the raw upper half
                p_raw_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    (vld_o && mode_o == SIZE_PAIR8) |->
                    (int'($signed(hi_o[i*CW +: CW])) == int'($past(xs[8+i]))));
            end
        end
    endgenerate

endmodule

// File: rtl/dct8_core.sv
`timescale 1ns/1ps
module dct8_core #(
    parameter int IN_W   = 9,
    parameter int SIDE_W = 1,
    parameter bit PIPE   = 1'b1,
    localparam int W1    = IN_W + 1,
    localparam int W2    = IN_W + 2,
    localparam int W3    = IN_W + 3,
    localparam int MIDN  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [SIDE_W-1:0] side_i,
    input  logic [8*IN_W-1:0] x_i,
    output logic              vld_o,
    output logic [SIDE_W-1:0] side_o,
    output logic [8*W3-1:0]   y_o
);

    // ---------------- stage A: mirror butterfly ----------------
    logic signed [IN_W-1:0] xv [8];
    logic [8*W1-1:0]        a_d;
    logic [8*W1-1:0]        a_q;
    logic [SIDE_W-1:0]      side_a;
    logic                   vld_a;

    generate
        for (genvar i = 0; i < 8; i++) begin : g_in
            assign xv[i] = $signed(x_i[i*IN_W +: IN_W]);
        end
        for (genvar i = 0; i < 4; i++) begin : g_bfly
            assign a_d[i*W1 +: W1]     = W1'(xv[i]) + W1'(xv[7-i]);
            assign a_d[(4+i)*W1 +: W1] = W1'(xv[i]) - W1'(xv[7-i]);
        end
    endgenerate

    dct_stage_reg #(.W(SIDE_W + 8*W1), .PIPE(PIPE)) u_sa (
        .clk (clk), .rst_n (rst_n), .vld_i (vld_i),
        .d_i ({side_i, a_d}), .vld_o (vld_a), .d_o ({side_a, a_q})
    );

    // ---------------- stage B: partial sums ----------------
    logic signed [W1-1:0] sv [4];
    logic signed [W1-1:0] dv [4];
    logic signed [W2-1:0] bv [MIDN];
    logic [MIDN*W2-1:0]   b_d;
    logic [MIDN*W2-1:0]   b_q;
    logic [SIDE_W-1:0]    side_b;
    logic                 vld_b;

    generate
        for (genvar i = 0; i < 4; i++) begin : g_sd
            assign sv[i] = $signed(a_q[i*W1 +: W1]);
            assign dv[i] = $signed(a_q[(4+i)*W1 +: W1]);
        end
    endgenerate

    assign bv[0]  = W2'(sv[0]) + W2'(sv[3]);
    assign bv[1]  = W2'(sv[1]) + W2'(sv[2]);
    assign bv[2]  = W2'(sv[0]) - W2'(sv[3]);
    assign bv[3]  = W2'(sv[2]) - W2'(sv[1]);
    assign bv[4]  = W2'(dv[0]) + W2'(dv[1]);
    assign bv[5]  = W2'(dv[0]) - W2'(dv[1]);
    assign bv[6]  = W2'(dv[2]) + W2'(dv[3]);
    assign bv[7]  = W2'(dv[2]) - W2'(dv[1]);
    assign bv[8]  = W2'(dv[0]);
    assign bv[9]  = W2'(dv[2]);
    assign bv[10] = W2'(dv[3]);

    generate
        for (genvar i = 0; i < MIDN; i++) begin : g_bpack
            assign b_d[i*W2 +: W2] = bv[i];
        end
    endgenerate

    dct_stage_reg #(.W(SIDE_W + MIDN*W2), .PIPE(PIPE)) u_sb (
        .clk (clk), .rst_n (rst_n), .vld_i (vld_a),
        .d_i ({side_a, b_d}), .vld_o (vld_b), .d_o ({side_b, b_q})
    );

    // ---------------- stage C: final coefficients ----------------
    logic signed [W2-1:0] mv [MIDN];
    logic signed [W3-1:0] yv [8];
    logic [8*W3-1:0]      c_d;

    generate
        for (genvar i = 0; i < MIDN; i++) begin : g_bunpack
            assign mv[i] = $signed(b_q[i*W2 +: W2]);
        end
    endgenerate

    assign yv[0] = W3'(mv[0]) + W3'(mv[1]);
    assign yv[4] = W3'(mv[0]) - W3'(mv[1]);
    assign yv[2] = W3'(mv[2]);
    assign yv[6] = W3'(mv[3]);
    assign yv[1] = W3'(mv[4]) + W3'(mv[9]);
    assign yv[3] = W3'(mv[8]) - W3'(mv[6]);
    assign yv[5] = W3'(mv[5]) + W3'(mv[10]);
    assign yv[7] = W3'(mv[7]) - W3'(mv[10]);

    generate
        for (genvar i = 0; i < 8; i++) begin : g_cpack
            assign c_d[i*W3 +: W3] = yv[i];
        end
    endgenerate

    dct_stage_reg #(.W(SIDE_W + 8*W3), .PIPE(PIPE)) u_sc (
        .clk (clk), .rst_n (rst_n), .vld_i (vld_b),
        .d_i ({side_b, c_d}), .vld_o (vld_o), .d_o ({side_o, y_o})
    );

    generate
        if (PIPE) begin : g_chk
            logic signed [W3-1:0] in_total;
            logic signed [W3-1:0] in_row1;

            always_comb begin
                in_total = '0;
                for (int i = 0; i < 8; i++) in_total = in_total + W3'(xv[i]);
                in_row1 = W3'(xv[0]) + W3'(xv[1]) + W3'(xv[2])
                        - W3'(xv[5]) - W3'(xv[6]) - W3'(xv[7]);
            end

            // R6: row 0 is the plain sum of the eight core inputs
            p_row0_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
                vld_o |-> ($signed(y_o[0 +: W3]) == $past(in_total, 3)));
            // R6: row 1 keeps the three nearest and removes the three farthest
            p_row1_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
                vld_o |-> ($signed(y_o[W3 +: W3]) == $past(in_row1, 3)));
        end
    endgenerate

endmodule

// File: rtl/dct_perm.sv
`timescale 1ns/1ps
module dct_perm
    import dct_recfg_pkg::*;
#(
    parameter int OW = 12
) (
    input  size_mode_e      mode_i,
    input  logic [8*OW-1:0] lo_i,
    input  logic [8*OW-1:0] hi_i,
    output logic [16*OW-1:0] y_o
);

    // Lanes 0 and 15 are fixed in both modes; the other fourteen switch.
    generate
        for (genvar k = 0; k < 8; k++) begin : g_lane
            always_comb begin
                unique case (mode_i)
                    SIZE_ONE16: begin
                        y_o[(2*k)*OW +: OW]   = lo_i[k*OW +: OW];
                        y_o[(2*k+1)*OW +: OW] = hi_i[k*OW +: OW];
                    end
                    SIZE_PAIR8: begin
                        y_o[(2*k)*OW +: OW]   = (2*k < 8) ? lo_i[(2*k)*OW +: OW]
                                                         : hi_i[(2*k-8)*OW +: OW];
                        y_o[(2*k+1)*OW +: OW] = (2*k+1 < 8) ? lo_i[(2*k+1)*OW +: OW]
                                                           : hi_i[(2*k-7)*OW +: OW];
                    end
                    default: begin
                        y_o[(2*k)*OW +: OW]   = '0;
                        y_o[(2*k+1)*OW +: OW] = '0;
                    end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/dct_reconfig16.sv
`timescale 1ns/1ps
module dct_reconfig16
    import dct_recfg_pkg::*;
#(
    parameter int IN_W = 8,
    parameter bit PIPE = 1'b1,
    localparam int CW  = IN_W + 1,
    localparam int OW  = IN_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_mode,
    input  logic [16*IN_W-1:0] in_samples,
    output logic               out_valid,
    output logic [16*OW-1:0]   out_coefs
);

    logic               r_vld;
    logic               r_mode;
    logic [16*IN_W-1:0] r_smp;

    dct_stage_reg #(.W(1 + 16*IN_W), .PIPE(PIPE)) u_in (
        .clk (clk), .rst_n (rst_n), .vld_i (in_valid),
        .d_i ({in_mode, in_samples}), .vld_o (r_vld), .d_o ({r_mode, r_smp})
    );

    logic            p_vld;
    size_mode_e      p_mode;
    logic [8*CW-1:0] p_lo;
    logic [8*CW-1:0] p_hi;

    dct_prep #(.IN_W(IN_W), .PIPE(PIPE)) u_prep (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (r_vld),
        .mode_i (size_mode_e'(r_mode)),
        .smp_i  (r_smp),
        .vld_o  (p_vld),
        .mode_o (p_mode),
        .lo_o   (p_lo),
        .hi_o   (p_hi)
    );

    logic            c_vld_lo;
    logic            c_vld_hi;
    logic [0:0]      side_lo;
    logic [0:0]      side_hi;
    logic [8*OW-1:0] y_lo;
    logic [8*OW-1:0] y_hi;

    dct8_core #(.IN_W(CW), .SIDE_W(1), .PIPE(PIPE)) u_core_lo (
        .clk (clk), .rst_n (rst_n), .vld_i (p_vld), .side_i (p_mode),
        .x_i (p_lo), .vld_o (c_vld_lo), .side_o (side_lo), .y_o (y_lo)
    );

    dct8_core #(.IN_W(CW), .SIDE_W(1), .PIPE(PIPE)) u_core_hi (
        .clk (clk), .rst_n (rst_n), .vld_i (p_vld), .side_i (p_mode),
        .x_i (p_hi), .vld_o (c_vld_hi), .side_o (side_hi), .y_o (y_hi)
    );

    logic [16*OW-1:0] perm_y;

    dct_perm #(.OW(OW)) u_perm (
        .mode_i (size_mode_e'(side_lo)),
        .lo_i   (y_lo),
        .hi_i   (y_hi),
        .y_o    (perm_y)
    );

    dct_stage_reg #(.W(16*OW), .PIPE(PIPE)) u_out (
        .clk (clk), .rst_n (rst_n), .vld_i (c_vld_lo),
        .d_i (perm_y), .vld_o (out_valid), .d_o (out_coefs)
    );

    generate
        if (PIPE) begin : g_chk
            logic [2:0] since_rst;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 since_rst <= '0;
                else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
            end

            // R8: both cores carry the same set and mode in lockstep
            p_cores_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (c_vld_lo == c_vld_hi) && (!c_vld_lo || side_lo == side_hi));
            // R7: output flag mirrors the input flag six edges earlier
            p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 3'd6) |-> (out_valid == $past(in_valid, 6)));
            // R1: nothing leaves the block in the first cycles after reset
            p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst < 3'd6) |-> !out_valid);
        end
    endgenerate

endmodule

// File: tb/dct_reconfig16_tb.sv
`timescale 1ns/1ps
module dct_reconfig16_tb;

    localparam int IN_W = 8;
    localparam int OW   = IN_W + 4;
    localparam int LAT  = 6;
    localparam int T8 [8][8] = '{
        '{ 1,  1,  1,  1,  1,  1,  1,  1},
        '{ 1,  1,  1,  0,  0, -1, -1, -1},
        '{ 1,  0,  0, -1, -1,  0,  0,  1},
        '{ 1,  0, -1, -1,  1,  1,  0, -1},
        '{ 1, -1, -1,  1,  1, -1, -1,  1},
        '{ 1, -1,  0,  1, -1,  0,  1, -1},
        '{ 0, -1,  1,  0,  0,  1, -1,  0},
        '{ 0, -1,  1, -1,  1, -1,  1,  0}
    };

    typedef struct {
        int     exp_v [16];
        bit     mode;
        longint stamp;
        string  tag;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_mode = 1'b0;
    logic [16*IN_W-1:0] in_samples = '0;
    logic               out_valid;
    logic [16*OW-1:0]   out_coefs;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    bit     done = 1'b0;
    item_t  sb [$];
    item_t  mon_it;
    int     mon_act [16];

    dct_reconfig16 #(.IN_W(IN_W), .PIPE(1'b1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_mode    (in_mode),
        .in_samples (in_samples),
        .out_valid  (out_valid),
        .out_coefs  (out_coefs)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_set(input int e [16], input int a [16], input int first,
                           input int stride, input int cnt, input string req,
                           input string what);
        int bad = -1;
        for (int n = 0; n < cnt; n++) begin
            int j = first + n * stride;
            if (bad < 0 && e[j] != a[j]) bad = j;
        end
        if (bad < 0) chk(1'b1, req, what, a[first], e[first]);
        else chk(1'b0, req, $sformatf("%s lane %0d", what, bad), a[bad], e[bad]);
    endtask

    function automatic void model(input int xs [16], input bit mode, output int e [16]);
        int va [8];
        int vb [8];
        for (int i = 0; i < 8; i++) begin
            if (mode) begin
                va[i] = xs[i] + xs[15-i];
                vb[i] = xs[i] - xs[15-i];
            end else begin
                va[i] = xs[i];
                vb[i] = xs[8+i];
            end
        end
        for (int k = 0; k < 8; k++) begin
            int sa = 0;
            int sbv = 0;
            for (int i = 0; i < 8; i++) begin
                sa  += T8[k][i] * va[i];
                sbv += T8[k][i] * vb[i];
            end
            if (mode) begin
                e[2*k]   = sa;
                e[2*k+1] = sbv;
            end else begin
                e[k]   = sa;
                e[8+k] = sbv;
            end
        end
    endfunction

    task automatic drive(input int xs [16], input bit mode, input string tag);
        item_t it;
        @(negedge clk);
        for (int i = 0; i < 16; i++) in_samples[i*IN_W +: IN_W] = IN_W'(xs[i]);
        in_mode  = mode;
        in_valid = 1'b1;
        model(xs, mode, it.exp_v);
        it.mode  = mode;
        it.stamp = cyc;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expected set per out_valid, checks timing and values.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7", "out_valid with empty scoreboard", 1, 0);
            end else begin
                mon_it = sb.pop_front();
                chk((cyc - mon_it.stamp) == LAT, "R7", "latency",
                    int'(cyc - mon_it.stamp), LAT);
                for (int j = 0; j < 16; j++)
                    mon_act[j] = int'($signed(out_coefs[j*OW +: OW]));
                if (mon_it.mode) begin
                    cmp_set(mon_it.exp_v, mon_act, 0, 2, 8, "R2", "even lanes 16-pt");
                    cmp_set(mon_it.exp_v, mon_act, 1, 2, 8, "R3", "odd lanes 16-pt");
                end else begin
                    cmp_set(mon_it.exp_v, mon_act, 0, 1, 8, "R4", "lower half 8-pt");
                    cmp_set(mon_it.exp_v, mon_act, 8, 1, 8, "R5", "upper half 8-pt");
                end
                if (mon_it.tag != "")
                    cmp_set(mon_it.exp_v, mon_act, 0, 1, 16, mon_it.tag, "whole set");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R7", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int xs [16];
        logic [31:0] lf = 32'h1F2E_3D4C;

        // R1: quiet during reset
        repeat (4) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        end
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        end

        // 16-point mode: ramp and full-scale patterns
        for (int i = 0; i < 16; i++) xs[i] = i * 7 - 50;
        drive(xs, 1'b1, "");
        for (int i = 0; i < 16; i++) xs[i] = 127;
        drive(xs, 1'b1, "R9");
        for (int i = 0; i < 16; i++) xs[i] = -128;
        drive(xs, 1'b1, "R9");
        for (int i = 0; i < 16; i++) xs[i] = (i < 8) ? 127 : -128;
        drive(xs, 1'b1, "R9");
        for (int i = 0; i < 16; i++) xs[i] = (i % 2 == 1) ? -128 : 127;
        drive(xs, 1'b1, "R9");
        idle(2);

        // R6: impulses in pair mode expose matrix columns
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < 16; i++) xs[i] = 0;
            xs[j]     = 1;
            xs[8 + j] = -1;
            drive(xs, 1'b0, "R6");
        end

        // R9: full scale in pair mode
        for (int i = 0; i < 16; i++) xs[i] = (i < 8) ? 127 : -128;
        drive(xs, 1'b0, "R9");
        for (int i = 0; i < 16; i++) xs[i] = (i < 8) ? -128 : 127;
        drive(xs, 1'b0, "R9");

        // R5: same upper half, different lower halves, back to back
        for (int i = 0; i < 16; i++) xs[i] = (i < 8) ? 100 - 30 * i : 3 * i - 40;
        drive(xs, 1'b0, "R5");
        for (int i = 0; i < 8; i++) xs[i] = -xs[i] + 5;
        drive(xs, 1'b0, "R5");
        idle(1);

        // R8: same samples, mode alternating every cycle
        for (int i = 0; i < 16; i++) xs[i] = (i * 37) % 251 - 125;
        for (int r = 0; r < 6; r++) drive(xs, r[0], "R8");
        idle(3);

        // Pseudo-random sets with random modes and occasional gaps
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < 16; i++) begin
                lf = lf ^ (lf << 13);
                lf = lf ^ (lf >> 17);
                lf = lf ^ (lf << 5);
                xs[i] = int'($signed(lf[7:0]));
            end
            drive(xs, lf[9], "");
            if (lf[12:10] == 3'd0) idle(2);
        end
        idle(LAT + 3);

        chk(sb.size() == 0, "R7", "sets left unanswered", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule